// File: doc/BRIEF.md
# Debug Event Capture and Routing

This block records five kinds of processor debug event and decides what each one does. The events are a halt or single-step request, a breakpoint instruction, a data watchpoint match, a vector catch and an external debug request. An event is only recorded when it is caught, meaning it causes some kind of stop. Which stop it causes depends on the debug configuration. With halting debug enabled, the core is held in debug state. With only the monitor enabled, a monitor handler call is requested, and that call waits for a priority grant. With neither enabled, the breakpoint and vector-catch events escalate to a hard fault, and the other events are dropped.

Software sees a 32-bit status word through a combinational read port. It clears flags by writing 1s through a single-cycle write strobe. The external request and the halt request wait for an instruction boundary before they act. The other three events act in the cycle they arrive. All outputs are registered.

Top module: `dbg_evt_router`

## Requirements
- R1: After reset the status word reads 0. Only five flag bits exist: bit 0 halt request, bit 1 breakpoint, bit 2 watchpoint, bit 3 vector catch, bit 4 external request. Bits 31..5 always read 0.
- R2: `reg_rdata` shows the current flags in the same cycle. A write with bit k = 1 clears flag k from the next cycle on. A write with bit k = 0 leaves flag k unchanged.
- R3: If a caught event and a write-1 hit the same flag in one cycle, the flag is set afterwards.
- R4: The catch rule depends on the mode. If `halt_en` is 1, every event is caught. If `halt_en` is 0 and `mon_en` is 1, every event is caught. If both are 0, only breakpoint and vector catch are caught. An uncaught event leaves its flag at 0.
- R5: In halt mode, `halt_o` rises in the cycle after a caught event. It stays high while `halt_en` is 1 and any flag is set. It falls in the cycle after the flags become all 0 or `halt_en` goes low.
- R6: In monitor mode, a caught event makes a request pending. `mon_req_o` is a one-cycle pulse in the cycle after a cycle in which the request is pending and `mon_allowed` is 1. The pending request is dropped when it is issued or when the block leaves monitor mode. While `mon_allowed` is 0, the flag stays set and no pulse is issued.
- R7: With both modes off, a caught breakpoint or vector catch makes `hf_dbgevt_o` pulse high in the next cycle. `hf_dbgevt_o` stays low in every other mode.
- R8: An external request or a halt request is held until a cycle with `insn_bound` = 1. It is then routed by the mode in force in that cycle. A request that arrives in a boundary cycle acts at once. Watchpoint, breakpoint and vector catch never wait.
- R9: Several flags can be set in the same cycle, and new flags add to flags that are already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_en | input | 1 | Halting debug enabled |
| mon_en | input | 1 | Debug monitor enabled |
| mon_allowed | input | 1 | Monitor priority grant |
| insn_bound | input | 1 | Instruction boundary in this cycle |
| ev_haltreq | input | 1 | Halt or step request event |
| ev_bkpt | input | 1 | Breakpoint instruction event |
| ev_wpt | input | 1 | Data watchpoint match event |
| ev_vcatch | input | 1 | Vector catch event |
| ev_ext | input | 1 | External debug request event |
| reg_wr | input | 1 | Status write strobe (write-1-to-clear) |
| reg_wdata | input | 32 | Status write data |
| reg_rdata | output | 32 | Status read data |
| halt_o | output | 1 | Core held in debug state |
| mon_req_o | output | 1 | Monitor handler call pulse |
| hf_dbgevt_o | output | 1 | Hard-fault escalation with debug-event cause |

## Verification
The bench uses the default parameters: a 32-bit data word, five events, the external and halt requests as the events that wait for a boundary, and breakpoint plus vector catch as the events that escalate to a fault. With these values, every mode can be reached by toggling the two enable inputs at run time. Both the deferred path and the immediate path are exercised. The bench also covers the escalation subset against the dropped subset, and a set colliding with a clear on the same flag.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int EV_N   = 5;
  localparam int B_HALT = 0;
  localparam int B_BKPT = 1;
  localparam int B_WPT  = 2;
  localparam int B_VC   = 3;
  localparam int B_EXT  = 4;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_MON  = 2'd1,
    MODE_HALT = 2'd2
  } dbg_mode_e;
endpackage

// File: rtl/dbg_evt_defer.sv
module dbg_evt_defer #(
  parameter int         N_EV  = 5,
  parameter logic [N_EV-1:0] DEFER = 5'b10001
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_EV-1:0] ev_i,
  input  logic            bound_i,
  output logic [N_EV-1:0] eff_o
);
  logic [N_EV-1:0] pend_q;

  for (genvar k = 0; k < N_EV; k++) begin : g_ev
    if (DEFER[k]) begin : g_wait
      // held until the next instruction boundary
      always_ff @(posedge clk) begin
        if (rst)          pend_q[k] <= 1'b0;
        else if (bound_i) pend_q[k] <= 1'b0;
        else if (ev_i[k]) pend_q[k] <= 1'b1;
      end
      assign eff_o[k] = bound_i & (pend_q[k] | ev_i[k]);

      assert_defer_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (pend_q[k] && !bound_i) |=> pend_q[k]);
      assert_defer_fire_R8: assert property (@(posedge clk) disable iff (rst)
        (eff_o[k]) |=> !pend_q[k]);
    end else begin : g_now
      assign pend_q[k] = 1'b0;
      assign eff_o[k]  = ev_i[k];
    end
  end
endmodule

// File: rtl/dbg_evt_classify.sv
module dbg_evt_classify
  import dbg_evt_pkg::*;
#(
  parameter int         N_EV  = 5,
  parameter logic [N_EV-1:0] FAULTS = 5'b01010
) (
  input  logic            halt_en_i,
  input  logic            mon_en_i,
  input  logic [N_EV-1:0] eff_i,
  output dbg_mode_e       mode_o,
  output logic [N_EV-1:0] catch_o
);
  always_comb begin
    if (halt_en_i)     mode_o = MODE_HALT;
    else if (mon_en_i) mode_o = MODE_MON;
    else               mode_o = MODE_OFF;
  end

  for (genvar k = 0; k < N_EV; k++) begin : g_cls
    if (FAULTS[k]) begin : g_fault
      assign catch_o[k] = eff_i[k];
    end else begin : g_drop
      assign catch_o[k] = eff_i[k] & (mode_o != MODE_OFF);
    end
  end
endmodule

// File: rtl/dbg_evt_status.sv
module dbg_evt_status #(
  parameter int N_EV   = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EV-1:0]   set_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_EV-1:0]   flags_o,
  output logic              any_next_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - N_EV;

  logic [N_EV-1:0] flags_q, flags_d, clr;

  assign clr        = wr_i ? wdata_i[N_EV-1:0] : '0;
  assign flags_d    = (flags_q & ~clr) | set_i;  // set wins
  assign any_next_o = |flags_d;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign rdata_o = {{PAD_W{1'b0}}, flags_q};

  for (genvar k = 0; k < N_EV; k++) begin : g_chk
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
      set_i[k] |=> flags_o[k]);
    assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_i && wdata_i[k] && !set_i[k]) |=> !flags_o[k]);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (flags_o[k] && !(wr_i && wdata_i[k])) |=> flags_o[k]);
  end
endmodule

// File: rtl/dbg_evt_action.sv
module dbg_evt_action
  import dbg_evt_pkg::*;
#(
  parameter int N_EV = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  dbg_mode_e       mode_i,
  input  logic [N_EV-1:0] catch_i,
  input  logic            any_next_i,
  input  logic            mon_allowed_i,
  output logic            halt_o,
  output logic            mon_req_o,
  output logic            hf_o
);
  logic caught, mon_pend_q, issue;

  assign caught = |catch_i;
  assign issue  = mon_pend_q & mon_allowed_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_o     <= 1'b0;
      mon_pend_q <= 1'b0;
      mon_req_o  <= 1'b0;
      hf_o       <= 1'b0;
    end else begin
      halt_o    <= (mode_i == MODE_HALT) & any_next_i & (halt_o | caught);
      mon_req_o <= (mode_i == MODE_MON) & issue;
      hf_o      <= (mode_i == MODE_OFF) & caught;
      if (mode_i != MODE_MON) mon_pend_q <= 1'b0;
      else                    mon_pend_q <= (mon_pend_q & ~issue) | caught;
    end
  end

  assert_halt_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_o) |-> $past(caught && mode_i == MODE_HALT));
  assert_halt_enter_R5: assert property (@(posedge clk) disable iff (rst)
    (caught && mode_i == MODE_HALT) |=> halt_o);
  assert_mon_gate_R6: assert property (@(posedge clk) disable iff (rst)
    mon_req_o |-> $past(mon_pend_q && mon_allowed_i));
  assert_mon_wait_R6: assert property (@(posedge clk) disable iff (rst)
    (mon_pend_q && !mon_allowed_i && mode_i == MODE_MON) |=> (mon_pend_q && !mon_req_o));
  assert_hf_mode_R7: assert property (@(posedge clk) disable iff (rst)
    hf_o |-> $past(mode_i == MODE_OFF));
endmodule

// File: rtl/dbg_evt_router.sv
module dbg_evt_router
  import dbg_evt_pkg::*;
#(
  parameter int              DATA_W = 32,
  parameter logic [EV_N-1:0] DEFER  = 5'b10001,
  parameter logic [EV_N-1:0] FAULTS = 5'b01010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_en,
  input  logic              mon_en,
  input  logic              mon_allowed,
  input  logic              insn_bound,
  input  logic              ev_haltreq,
  input  logic              ev_bkpt,
  input  logic              ev_wpt,
  input  logic              ev_vcatch,
  input  logic              ev_ext,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              halt_o,
  output logic              mon_req_o,
  output logic              hf_dbgevt_o
);
  logic [EV_N-1:0] ev_vec, eff, catch_v, flags;
  logic            any_next;
  dbg_mode_e       mode;

  always_comb begin
    ev_vec         = '0;
    ev_vec[B_HALT] = ev_haltreq;
    ev_vec[B_BKPT] = ev_bkpt;
    ev_vec[B_WPT]  = ev_wpt;
    ev_vec[B_VC]   = ev_vcatch;
    ev_vec[B_EXT]  = ev_ext;
  end

  dbg_evt_defer #(.N_EV(EV_N), .DEFER(DEFER)) u_defer (
    .clk(clk), .rst(rst), .ev_i(ev_vec), .bound_i(insn_bound), .eff_o(eff)
  );

  dbg_evt_classify #(.N_EV(EV_N), .FAULTS(FAULTS)) u_cls (
    .halt_en_i(halt_en), .mon_en_i(mon_en), .eff_i(eff),
    .mode_o(mode), .catch_o(catch_v)
  );

  dbg_evt_status #(.N_EV(EV_N), .DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .set_i(catch_v), .wr_i(reg_wr), .wdata_i(reg_wdata),
    .flags_o(flags), .any_next_o(any_next), .rdata_o(reg_rdata)
  );

  dbg_evt_action #(.N_EV(EV_N)) u_act (
    .clk(clk), .rst(rst), .mode_i(mode), .catch_i(catch_v),
    .any_next_i(any_next), .mon_allowed_i(mon_allowed),
    .halt_o(halt_o), .mon_req_o(mon_req_o), .hf_o(hf_dbgevt_o)
  );

  assert_reserved_R1: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:EV_N] == '0);
  assert_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (!halt_en && !mon_en && ev_wpt && !flags[B_WPT]) |=> !flags[B_WPT]);
  assert_halt_flags_R5: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> (flags != '0));
endmodule

// File: tb/dbg_evt_router_tb.sv
module dbg_evt_router_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_en = 0, mon_en = 0, mon_allowed = 0, insn_bound = 0;
  logic ev_haltreq = 0, ev_bkpt = 0, ev_wpt = 0, ev_vcatch = 0, ev_ext = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic halt_o, mon_req_o, hf_dbgevt_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [4:0] m_stat = '0, m_pend = '0;
  logic m_halt = 0, m_mpend = 0, m_mreq = 0, m_hf = 0;

  always #2 clk = ~clk;

  dbg_evt_router u_dut (
    .clk(clk), .rst(rst), .halt_en(halt_en), .mon_en(mon_en),
    .mon_allowed(mon_allowed), .insn_bound(insn_bound),
    .ev_haltreq(ev_haltreq), .ev_bkpt(ev_bkpt), .ev_wpt(ev_wpt),
    .ev_vcatch(ev_vcatch), .ev_ext(ev_ext), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halt_o(halt_o),
    .mon_req_o(mon_req_o), .hf_dbgevt_o(hf_dbgevt_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model: behavioural, per clock
  always @(posedge clk) begin
    logic [4:0] ev, eff, cat, nxt;
    int mode; // 2 halt, 1 monitor, 0 off
    cyc++;
    if (rst) begin
      m_stat = '0; m_pend = '0; m_halt = 0; m_mpend = 0; m_mreq = 0; m_hf = 0;
    end else begin
      mode = halt_en ? 2 : (mon_en ? 1 : 0);
      ev = {ev_ext, ev_vcatch, ev_wpt, ev_bkpt, ev_haltreq};
      eff = ev;
      foreach (eff[i]) if (i == 0 || i == 4) begin
        eff[i] = insn_bound && (m_pend[i] || ev[i]);
        m_pend[i] = insn_bound ? 1'b0 : (m_pend[i] || ev[i]);
      end
      cat = eff;
      if (mode == 0) cat = eff & 5'b01010;
      nxt = m_stat & ~(reg_wr ? reg_wdata[4:0] : 5'b0);
      nxt = nxt | cat;
      m_halt = (mode == 2) && (nxt != 0) && (m_halt || cat != 0);
      m_hf = (mode == 0) && (cat != 0);
      m_mreq = (mode == 1) && m_mpend && mon_allowed;
      if (mode != 1) m_mpend = 0;
      else m_mpend = (m_mpend && !mon_allowed) || (cat != 0);
      m_stat = nxt;
    end
  end

  always @(negedge clk) if (!rst) begin
    chk(reg_rdata == {27'b0, m_stat}, "R2 status", reg_rdata, {27'b0, m_stat});
    chk(halt_o == m_halt, "R5 halt", halt_o, m_halt);
    chk(mon_req_o == m_mreq, "R6 monitor", mon_req_o, m_mreq);
    chk(hf_dbgevt_o == m_hf, "R7 fault", hf_dbgevt_o, m_hf);
  end

  always @(posedge clk) if (cyc > 20000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected <20000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_in;
    {ev_haltreq, ev_bkpt, ev_wpt, ev_vcatch, ev_ext, insn_bound, reg_wr} = '0;
    reg_wdata = '0;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d; tick(); clr_in();
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick();
    chk(reg_rdata == 0, "R1 reset", reg_rdata, 0);
    // off mode: breakpoint escalates, watchpoint/ext dropped
    ev_bkpt = 1; tick(); clr_in();
    chk(hf_dbgevt_o == 1, "R7 fault pulse", hf_dbgevt_o, 1);
    ev_wpt = 1; ev_ext = 1; insn_bound = 1; tick(); clr_in();
    chk(reg_rdata == 32'h2, "R4 dropped in off mode", reg_rdata, 32'h2);
    ev_vcatch = 1; tick(); clr_in();
    chk(reg_rdata == 32'hA, "R9 accumulate", reg_rdata, 32'hA);
    wr(32'hFFFF_FFE0); tick();
    chk(reg_rdata == 32'hA, "R2 write reserved only", reg_rdata, 32'hA);
    wr(32'h0000_0008);
    chk(reg_rdata == 32'h2, "R2 clear one", reg_rdata, 32'h2);
    // set wins over clear
    ev_bkpt = 1; reg_wr = 1; reg_wdata = 32'h2; tick(); clr_in();
    chk(reg_rdata == 32'h2, "R3 set wins", reg_rdata, 32'h2);
    wr(32'hFFFF_FFFF);
    chk(reg_rdata == 0, "R2 clear all", reg_rdata, 0);
    // halt mode
    halt_en = 1;
    ev_wpt = 1; tick(); clr_in();
    chk(halt_o == 1, "R5 halt enter", halt_o, 1);
    tick(3);
    chk(halt_o == 1, "R5 halt hold", halt_o, 1);
    wr(32'h4);
    chk(halt_o == 0, "R5 halt release", halt_o, 0);
    // deferred halt request
    ev_haltreq = 1; tick(); clr_in(); tick(3);
    chk(reg_rdata == 0, "R8 wait boundary", reg_rdata, 0);
    insn_bound = 1; tick(); clr_in();
    chk(reg_rdata == 32'h1, "R8 at boundary", reg_rdata, 32'h1);
    ev_ext = 1; insn_bound = 1; ev_bkpt = 1; ev_wpt = 1; ev_vcatch = 1; tick(); clr_in();
    chk(reg_rdata == 32'h1F, "R9 all at once", reg_rdata, 32'h1F);
    wr(32'h1F);
    halt_en = 0; tick(2);
    // pending ext request then mode off at boundary -> dropped
    ev_ext = 1; tick(); clr_in(); insn_bound = 1; tick(); clr_in();
    chk(reg_rdata == 0, "R8 routed by mode at boundary", reg_rdata, 0);
    // monitor mode with priority blocked
    mon_en = 1;
    ev_wpt = 1; tick(); clr_in(); tick(4);
    chk(mon_req_o == 0 && reg_rdata == 32'h4, "R6 blocked", {mon_req_o, reg_rdata[30:0]}, 32'h4);
    mon_allowed = 1; tick();
    chk(mon_req_o == 1, "R6 issue", mon_req_o, 1);
    tick();
    chk(mon_req_o == 0, "R6 single pulse", mon_req_o, 0);
    ev_bkpt = 1; tick(); clr_in(); tick(3);
    chk(hf_dbgevt_o == 0, "R7 none in monitor", hf_dbgevt_o, 0);
    mon_allowed = 0; wr(32'hFFFF_FFFF);
    mon_en = 0; tick(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule